// File: doc/BRIEF.md
# Serial Transmit Handshake Port

This block sits between a media access controller and the transmit path of a spread-spectrum modem. It receives payload bits one at a time from the controller and groups them into words for the modulator. It also drives the bit clock that the controller uses to present those bits. A single enable input frames each transmission. While the enable is low the port is idle and its outputs are quiet. A rising edge on the enable starts a new window, and a falling edge ends it at once.

The port has two modes for the start of a window:

- **Internal preamble mode.** The port first waits through a preamble and header phase that lasts a programmable number of bit periods. It then raises a ready flag to tell the controller to start sending payload.
- **External preamble mode.** The controller supplies everything itself, so the bit clock starts as soon as the window opens and the ready flag stays low.

The bit clock comes from the master clock through a divide-by-1, 2, 4 or 8 setting. By default bits are captured on the falling edge of the bit clock, and a configuration input moves capture to the rising edge. The mode, divider, capture edge and header length are all sampled when the window opens.

Top module: `tx_serial_port`

## Requirements
- R1: While `tx_en_i` is low, `bclk_o`, `rdy_o`, `bit_vld_o` and `word_vld_o` are low and `txd_i` has no effect; this is also the state after reset.
- R2: In external preamble mode (`int_hdr_i`=0 when the window opens), `rdy_o` stays low for the whole window and the bit clock runs from the start of the window.
- R3: In internal preamble mode with header length L>0 and divide ratio D, `rdy_o` rises exactly 2·L·D clock cycles after the clock edge that first sees `tx_en_i` high, and `bclk_o` stays low until then.
- R4: `div_sel_i` values 0,1,2,3 select D=1,2,4,8. `bclk_o` has a period of 2·D cycles and first rises D cycles after the data-accept phase begins.
- R5: With `cap_rise_i`=0, `txd_i` is sampled at the clock edge where `bclk_o` falls. With `cap_rise_i`=1, it is sampled where `bclk_o` rises.
- R6: Bits are assembled least significant bit first: the first captured bit of a word lands in `word_o[0]`. After every 8th capture, `word_vld_o` pulses high for exactly one cycle.
- R7: Each capture is reported on `bit_o` with a one-cycle `bit_vld_o` pulse, in the cycle after the capture edge.
- R8: When `tx_en_i` falls, the next clock edge drives `rdy_o` and `bclk_o` low, and a partly assembled word is dropped. The next window starts a new word.
- R9: The mode, capture edge, divide ratio and header length are sampled on the rising edge of the enable. Changing them during a window has no effect on that window.
- R10: In internal preamble mode with L=0, the header phase is skipped and `rdy_o` rises on the edge that opens the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit window enable |
| int_hdr_i | input | 1 | 1 = preamble/header generated internally |
| cap_rise_i | input | 1 | 1 = capture on rising bit-clock edge, 0 = falling |
| div_sel_i | input | 2 | Bit clock divide select (D = 2^value) |
| hdr_len_i | input | HDR_W | Header phase length in bit periods |
| txd_i | input | 1 | Serial payload bit from the controller |
| bclk_o | output | 1 | Bit clock toward the controller |
| rdy_o | output | 1 | Ready for payload (internal preamble mode) |
| bit_o | output | 1 | Last captured bit |
| bit_vld_o | output | 1 | One-cycle strobe for `bit_o` |
| word_o | output | WORD_W | Assembled word, first bit in bit 0 |
| word_vld_o | output | 1 | One-cycle strobe for `word_o` |

## Verification
The hardest case to reach is a change of configuration in the middle of a window. The settings are sampled only when the enable rises, so the change must land after capture has started and must still leave the old settings in force. The bench's controller model inverts every configuration input right after the first captured bit. It then keeps measuring the bit clock period and the captured bit values against the settings from the window's start. A second hard case is a window aborted partway through a word. To reach it, the bench closes a window after three bits and checks that the following window still delivers a correctly aligned word.

// File: rtl/tx_port_pkg.sv
package tx_port_pkg;
  localparam int DIV_CNT_W = 3;  // supports divide by up to 8

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic       int_hdr;
    logic       cap_rise;
    logic [1:0] div_sel;
  } tx_cfg_t;

  function automatic logic [DIV_CNT_W-1:0] div_limit(input logic [1:0] sel);
    logic [DIV_CNT_W:0] r;
    r = (DIV_CNT_W+1)'(1) << sel;
    return DIV_CNT_W'(r - (DIV_CNT_W+1)'(1));
  endfunction
endpackage

// File: rtl/tx_port_tick.sv
module tx_port_tick
  import tx_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] div_sel_i,
  output logic       tick_o
);
  logic [DIV_CNT_W-1:0] cnt_q;
  logic [DIV_CNT_W-1:0] lim;

  assign lim    = div_limit(div_sel_i);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_CNT_W'(1);
  end
endmodule

// File: rtl/tx_port_ctrl.sv
module tx_port_ctrl
  import tx_port_pkg::*;
#(
  parameter int HDR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  tx_cfg_t          cfg_i,
  input  logic [HDR_W-1:0] hdr_len_i,
  input  logic             tick_i,
  output tx_state_e        state_o,
  output tx_cfg_t          cfg_o,
  output logic             bclk_o,
  output logic             rdy_o,
  output logic             cap_o
);
  localparam int HC_W = HDR_W + 1;

  tx_state_e        state_q;
  tx_cfg_t          cfg_q;
  logic [HDR_W-1:0] len_q;
  logic [HC_W-1:0]  half_q;
  logic [HC_W-1:0]  half_last;
  logic             en_q, bclk_q, en_rise;

  assign en_rise   = tx_en_i && !en_q;
  assign half_last = {len_q, 1'b0} - HC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      len_q   <= '0;
      half_q  <= '0;
      bclk_q  <= 1'b0;
    end else begin
      en_q <= tx_en_i;
      if (!tx_en_i) begin
        state_q <= ST_IDLE;
        bclk_q  <= 1'b0;
        half_q  <= '0;
      end else if (en_rise) begin
        cfg_q   <= cfg_i;
        len_q   <= hdr_len_i;
        half_q  <= '0;
        bclk_q  <= 1'b0;
        state_q <= (cfg_i.int_hdr && (hdr_len_i != '0)) ? ST_HDR : ST_DATA;
      end else begin
        unique case (state_q)
          ST_HDR: if (tick_i) begin
            if (half_q == half_last) begin
              state_q <= ST_DATA;
              half_q  <= '0;
            end else begin
              half_q <= half_q + HC_W'(1);
            end
          end
          ST_DATA: if (tick_i) bclk_q <= ~bclk_q;
          default: ;
        endcase
      end
    end
  end

  // capture on the selected bit-clock transition
  assign cap_o   = tx_en_i && (state_q == ST_DATA) && tick_i && (bclk_q ^ cfg_q.cap_rise);
  assign rdy_o   = (state_q == ST_DATA) && cfg_q.int_hdr;
  assign bclk_o  = bclk_q;
  assign state_o = state_q;
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/tx_port_deser.sv
module tx_port_deser #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic              txd_i,
  output logic              bit_o,
  output logic              bit_vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sr_q, sr_nxt;
  logic [CNT_W-1:0]  cnt_q;

  assign sr_nxt = {txd_i, sr_q[WORD_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      bit_o      <= 1'b0;
      bit_vld_o  <= 1'b0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q      <= '0;
      bit_vld_o  <= 1'b0;
      word_vld_o <= 1'b0;
    end else begin
      bit_vld_o  <= cap_i;
      word_vld_o <= 1'b0;
      if (cap_i) begin
        bit_o <= txd_i;
        sr_q  <= sr_nxt;
        if (cnt_q == CNT_W'(WORD_W-1)) begin
          word_o     <= sr_nxt;
          word_vld_o <= 1'b1;
          cnt_q      <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tx_serial_port.sv
module tx_serial_port
  import tx_port_pkg::*;
#(
  parameter int HDR_W  = 8,
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              int_hdr_i,
  input  logic              cap_rise_i,
  input  logic [1:0]        div_sel_i,
  input  logic [HDR_W-1:0]  hdr_len_i,
  input  logic              txd_i,
  output logic              bclk_o,
  output logic              rdy_o,
  output logic              bit_o,
  output logic              bit_vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  tx_cfg_t   cfg_in, cfg_q;
  tx_state_e state_q;
  logic      tick, cap, run;

  assign cfg_in = '{int_hdr: int_hdr_i, cap_rise: cap_rise_i, div_sel: div_sel_i};
  assign run    = (state_q != ST_IDLE);

  tx_port_tick u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .div_sel_i (cfg_q.div_sel),
    .tick_o    (tick)
  );

  tx_port_ctrl #(.HDR_W(HDR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_en_i   (tx_en_i),
    .cfg_i     (cfg_in),
    .hdr_len_i (hdr_len_i),
    .tick_i    (tick),
    .state_o   (state_q),
    .cfg_o     (cfg_q),
    .bclk_o    (bclk_o),
    .rdy_o     (rdy_o),
    .cap_o     (cap)
  );

  tx_port_deser #(.WORD_W(WORD_W)) u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (state_q != ST_DATA),
    .cap_i      (cap),
    .txd_i      (txd_i),
    .bit_o      (bit_o),
    .bit_vld_o  (bit_vld_o),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
  );
endmodule

// File: rtl/tx_serial_port_chk.sv
module tx_serial_port_chk
  import tx_port_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      tx_en_i,
  input logic      bclk_o,
  input logic      rdy_o,
  input logic      bit_vld_o,
  input logic      word_vld_o,
  input tx_state_e state_q,
  input tx_cfg_t   cfg_q
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (!bclk_o && !rdy_o && !bit_vld_o && !word_vld_o));

  p_ext_no_rdy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.int_hdr |-> !rdy_o);

  p_hdr_clk_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR) |-> (!bclk_o && !rdy_o));

  p_cap_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> ((bclk_o == cfg_q.cap_rise) && (bclk_o != $past(bclk_o))));

  p_word_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  p_rdy_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> $past(tx_en_i));
endmodule

bind tx_serial_port tx_serial_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_en_i    (tx_en_i),
  .bclk_o     (bclk_o),
  .rdy_o      (rdy_o),
  .bit_vld_o  (bit_vld_o),
  .word_vld_o (word_vld_o),
  .state_q    (state_q),
  .cfg_q      (cfg_q)
);

// File: tb/tx_serial_port_tb_top.sv
module tx_serial_port_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b0;
  logic       int_hdr_i = 1'b0;
  logic       cap_rise_i = 1'b0;
  logic [1:0] div_sel_i = 2'd0;
  logic [7:0] hdr_len_i = 8'd0;
  logic       txd_i = 1'b0;
  logic       bclk_o, rdy_o, bit_o, bit_vld_o, word_vld_o;
  logic [7:0] word_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  tx_serial_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .int_hdr_i(int_hdr_i),
    .cap_rise_i(cap_rise_i), .div_sel_i(div_sel_i), .hdr_len_i(hdr_len_i),
    .txd_i(txd_i), .bclk_o(bclk_o), .rdy_o(rdy_o), .bit_o(bit_o),
    .bit_vld_o(bit_vld_o), .word_o(word_o), .word_vld_o(word_vld_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(input logic [7:0] seed, input int k);
    return 8'(seed + 8'(k * 53));
  endfunction

  function automatic logic exp_bit(input logic [7:0] seed, input int i);
    logic [7:0] w;
    w = exp_word(seed, i / 8);
    return w[i % 8];
  endfunction

  // one transmit window driven by a controller model that follows bclk_o
  task automatic run_window(input logic im, input logic cr, input logic [1:0] ds,
                            input int len, input int nbits, input logic [7:0] seed,
                            input bit chg_cfg);
    int  d, cyc, idx, words, last_rise, first_rise, hdr_cyc;
    bit  prev, rdy_seen, rdy_ever, hdr_clk_bad, cap_ev;
    d = 1 << ds;
    hdr_cyc = im ? 2 * len * d : 0;
    cyc = 0; idx = 0; words = 0; last_rise = -1; first_rise = -1;
    prev = 0; rdy_seen = 0; rdy_ever = 0; hdr_clk_bad = 0;
    @(negedge clk_i);
    int_hdr_i = im; cap_rise_i = cr; div_sel_i = ds; hdr_len_i = 8'(len);
    txd_i = exp_bit(seed, 0);
    tx_en_i = 1'b1;
    while (idx < nbits && cyc < 5000) begin
      @(negedge clk_i);
      cyc++;
      if (rdy_o) rdy_ever = 1;
      if (im && !rdy_seen && rdy_o) begin
        rdy_seen = 1;
        if (len == 0) check(cyc == 1, "R10 ready timing", cyc, 1);
        else          check(cyc == hdr_cyc + 1, "R3 ready timing", cyc, hdr_cyc + 1);
      end
      if (im && !rdy_seen && bclk_o) hdr_clk_bad = 1;
      if (word_vld_o) begin
        check(word_o == exp_word(seed, words), "R6 word value", word_o, exp_word(seed, words));
        words++;
      end
      if (bclk_o && !prev) begin
        if (last_rise >= 0) check(cyc - last_rise == 2 * d, "R4/R9 bclk period", cyc - last_rise, 2 * d);
        else first_rise = cyc;
        last_rise = cyc;
      end
      cap_ev = cr ? (bclk_o && !prev) : (!bclk_o && prev);
      if (cap_ev) begin
        check(bit_vld_o && bit_o == exp_bit(seed, idx), "R7 bit strobe", {bit_vld_o, bit_o},
              {1'b1, exp_bit(seed, idx)});
        idx++;
        if (idx < nbits) txd_i = exp_bit(seed, idx);
        if (chg_cfg && idx == 1) begin
          int_hdr_i = ~im; cap_rise_i = ~cr; div_sel_i = ~ds; hdr_len_i = 8'(len + 7);
        end
      end else begin
        check(!bit_vld_o, "R5 no capture off edge", bit_vld_o, 0);
      end
      prev = bclk_o;
    end
    check(idx == nbits, "R5 all bits captured", idx, nbits);
    check(first_rise == hdr_cyc + d + 1, "R4 first bclk rise", first_rise, hdr_cyc + d + 1);
    if (im) check(!hdr_clk_bad && rdy_seen, "R3 bclk low in header", hdr_clk_bad, 0);
    else    check(!rdy_ever, "R2 ready low in external mode", rdy_ever, 0);
    tx_en_i = 1'b0;
    @(negedge clk_i);
    check(!rdy_o && !bclk_o && !bit_vld_o, "R8 window close", {rdy_o, bclk_o, bit_vld_o}, 0);
    check(words == nbits / 8, "R6 word count", words, nbits / 8);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset_idle();
    check(!bclk_o && !rdy_o && !bit_vld_o && !word_vld_o, "R1 reset state",
          {bclk_o, rdy_o, bit_vld_o, word_vld_o}, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      txd_i = ~txd_i;
      check(!bclk_o && !rdy_o && !bit_vld_o && !word_vld_o, "R1 idle ignores txd",
            {bclk_o, rdy_o, bit_vld_o, word_vld_o}, 0);
    end
  endtask

  task automatic t_ext_falling();  run_window(1'b0, 1'b0, 2'd0, 0, 16, 8'hA5, 1'b0); endtask
  task automatic t_ext_rising();   run_window(1'b0, 1'b1, 2'd2, 0, 16, 8'h3C, 1'b0); endtask
  task automatic t_int_header();   run_window(1'b1, 1'b0, 2'd1, 5, 16, 8'h71, 1'b0); endtask
  task automatic t_int_div8();     run_window(1'b1, 1'b1, 2'd3, 2, 8,  8'hC2, 1'b0); endtask
  task automatic t_int_zero_len(); run_window(1'b1, 1'b0, 2'd0, 0, 8,  8'h5E, 1'b0); endtask
  task automatic t_abort_partial();
    run_window(1'b0, 1'b0, 2'd1, 0, 3, 8'hFF, 1'b0);
    run_window(1'b0, 1'b0, 2'd1, 0, 8, 8'h96, 1'b0);
  endtask
  task automatic t_cfg_midwindow(); run_window(1'b1, 1'b0, 2'd2, 3, 24, 8'h0D, 1'b1); endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_idle();
    t_ext_falling();
    t_ext_rising();
    t_int_header();
    t_int_div8();
    t_int_zero_len();
    t_abort_partial();
    t_cfg_midwindow();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule